// File: doc/BRIEF.md
# Fast Reset and A20 Gate Control

This block is the legacy reset and address-line-20 corner of a chipset control unit. Software reaches it through two byte registers on a simple register bus (address, write strobe, read strobe, write data, read data). One is a reset-control register whose two top bits, written together as 1, ask for a fast hardware reset. The other is the system control port at I/O address 92h, whose bit 1 opens the A20 gate directly.

An accepted reset request produces a one-cycle `fast_reset_req` strobe and an active-high `cpu_reset` pulse. Both are synchronous to `clk`. The pulse width is either a short or a long latency, given in microseconds and converted to clock cycles from the `CLK_FREQ_HZ` parameter. The A20 gate output is the OR of port bit 1 and the keyboard controller's gate-A20 input.

The sequencing is a two-state machine:
- In `ST_IDLE`, the transition `GO_HOLD` is taken on an accepted request, and the down-counter is loaded.
- In `ST_HOLD`, `cpu_reset` is driven high, and the transition `GO_IDLE` is taken when the counter reaches zero.

Top module: `legacy_reset_a20_ctl`

## Requirements
- R1: After reset, both registers read 0x00, and `a20_gate` (with `kbc_a20` low), `cpu_reset`, `fast_reset_req` and `port_unsup` are all 0.
- R2: A write to the control register with bits 7 and 6 both 1, made while no pulse is running, raises `fast_reset_req` for exactly the one cycle after the write edge. `cpu_reset` rises in that same cycle.
- R3: The width of `cpu_reset` in cycles is LONG_US×CLK_FREQ_HZ/10^6 when bit 3 of the accepted write is 1. It is SHORT_US×CLK_FREQ_HZ/10^6 when bit 3 is 0.
- R4: A control write whose bits 7:6 are not both 1 stores its value and produces neither a strobe nor a pulse.
- R5: A qualifying control write made while `cpu_reset` is high is stored but otherwise ignored. It produces no strobe and does not change the running pulse.
- R6: With `rd_en` high, `rdata` shows the control register at `CTRL_ADDR` and the last value written to the port at `PORT_ADDR` (all 8 bits), and 0 at any other address. With `rd_en` low, `rdata` is 0.
- R7: `a20_gate` equals bit 1 of the port register OR `kbc_a20`, and follows a port write on the next cycle.
- R8: `port_unsup` is 1 exactly when the stored port value has any bit other than bit 1 set (value AND 0xFD nonzero). Such values are still stored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| kbc_a20 | input | 1 | Gate-A20 request from the keyboard controller |
| a20_gate | output | 1 | A20 gate line |
| cpu_reset | output | 1 | Active-high CPU reset pulse |
| fast_reset_req | output | 1 | One-cycle strobe on each accepted reset request |
| port_unsup | output | 1 | Port holds a value with unsupported bits set |

## Verification
The bench builds the block with `CLK_FREQ_HZ` = 2 MHz and the default latencies of 2 µs and 6 µs. The short and long pulses therefore last 4 and 12 cycles, so both widths can be observed edge to edge.

At that scale, a second request can land inside a running pulse, on its last cycle, and on the cycle right after it ends, all within a short run. Every output is compared with a behavioural model on each clock.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

    localparam int TRIG_HI_BIT = 7;
    localparam int TRIG_LO_BIT = 6;
    localparam int LAT_BIT     = 3;
    localparam int GATE_BIT    = 1;
    localparam logic [7:0] UNSUP_MASK = 8'hFD;
endpackage

// File: rtl/lrc_regs.sv
module lrc_regs
    import lrc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    input  logic              kbc_a20,
    output logic [7:0]        bus_rdata,
    output logic              a20_gate,
    output logic              port_unsup,
    output logic              trig,
    output logic              long_sel
);
    logic [7:0] ctrl_q;
    logic [7:0] port_q;
    logic       ctrl_hit;
    logic       port_hit;

    assign ctrl_hit = (bus_addr == CTRL_ADDR);
    assign port_hit = (bus_addr == PORT_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            port_q     <= '0;
            port_unsup <= 1'b0;
        end else begin
            if (bus_wr && ctrl_hit) ctrl_q <= bus_wdata;
            if (bus_wr && port_hit) begin
                port_q     <= bus_wdata;
                port_unsup <= |(bus_wdata & UNSUP_MASK);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (ctrl_hit)      bus_rdata = ctrl_q;
            else if (port_hit) bus_rdata = port_q;
        end
    end

    assign a20_gate = port_q[GATE_BIT] | kbc_a20;
    assign trig     = bus_wr && ctrl_hit && bus_wdata[TRIG_HI_BIT] && bus_wdata[TRIG_LO_BIT];
    assign long_sel = bus_wdata[LAT_BIT];

    // R4: a control write is stored whatever its top bits hold
    p_ctrl_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_hit) |=> (ctrl_q == $past(bus_wdata)));
    // R6: the port keeps every bit of the last write
    p_port_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && port_hit) |=> (port_q == $past(bus_wdata)));
    // R8: the status flag tracks unsupported bits of the written value
    p_unsup_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && port_hit) |=> (port_unsup == ($past(bus_wdata & UNSUP_MASK) != 8'h00)));
endmodule

// File: rtl/lrc_pulse_fsm.sv
module lrc_pulse_fsm
    import lrc_pkg::*;
#(
    parameter int SHORT_CYC = 66,
    parameter int LONG_CYC  = 198
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic long_sel,
    output logic cpu_reset,
    output logic fast_req
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);

    hold_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             req_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        req_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d = ST_HOLD;
                    cnt_d   = long_sel ? LONG_LOAD : SHORT_LOAD;
                    req_d   = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            fast_req <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            fast_req <= req_d;
        end
    end

    always_comb begin
        cpu_reset = (state_q == ST_HOLD);
    end

    // R2: the strobe only appears alongside a running pulse
    p_req_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |-> cpu_reset);
    // R2: an idle request is accepted on the write edge
    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cpu_reset) |=> (fast_req && cpu_reset));
    // R5: nothing is accepted while a pulse is running
    p_no_retrigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |=> !fast_req);
    // R3: the remaining count never exceeds the long latency
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LONG_LOAD));
endmodule

// File: rtl/legacy_reset_a20_ctl.sv
module legacy_reset_a20_ctl #(
    parameter int ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0010,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int CLK_FREQ_HZ = 33_000_000,
    parameter int SHORT_US    = 2,
    parameter int LONG_US     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kbc_a20,
    output logic              a20_gate,
    output logic              cpu_reset,
    output logic              fast_reset_req,
    output logic              port_unsup
);
    localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
    localparam int SHORT_CYC  = (SHORT_US * CYC_PER_US < 1) ? 1 : SHORT_US * CYC_PER_US;
    localparam int LONG_CYC   = (LONG_US * CYC_PER_US < SHORT_CYC) ? SHORT_CYC : LONG_US * CYC_PER_US;

    logic trig;
    logic long_sel;

    lrc_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .PORT_ADDR (PORT_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .kbc_a20    (kbc_a20),
        .bus_rdata  (bus_rdata),
        .a20_gate   (a20_gate),
        .port_unsup (port_unsup),
        .trig       (trig),
        .long_sel   (long_sel)
    );

    lrc_pulse_fsm #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .long_sel  (long_sel),
        .cpu_reset (cpu_reset),
        .fast_req  (fast_reset_req)
    );
endmodule

// File: tb/test_legacy_reset_a20_ctl.sv
`timescale 1ns/1ps
module test_legacy_reset_a20_ctl;
    localparam int CLK_HZ = 2_000_000;
    localparam int WS = 4;
    localparam int WL = 12;
    localparam logic [15:0] CA = 16'h0010;
    localparam logic [15:0] PA = 16'h0092;

    logic clk = 0;
    logic rst_n = 0;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = '0;
    logic kbc_a20 = 0;
    logic [7:0] bus_rdata;
    logic a20_gate, cpu_reset, fast_reset_req, port_unsup;

    int checks = 0, fails = 0;
    int m_ctrl = 0, m_port = 0, m_busy = 0, m_req = 0;
    int exp_pulses = 0, seen_pulses = 0;
    int cur_w = 0, exp_w = 0;
    bit done = 0;

    always #2 clk = ~clk;

    legacy_reset_a20_ctl #(.CLK_FREQ_HZ(CLK_HZ)) i_legacy_reset_a20_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbc_a20(kbc_a20),
        .a20_gate(a20_gate), .cpu_reset(cpu_reset), .fast_reset_req(fast_reset_req),
        .port_unsup(port_unsup)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_port = 0; m_busy = 0; m_req = 0;
        end else begin
            int nb;
            nb = (m_busy > 0) ? m_busy - 1 : 0;
            m_req = 0;
            if (bus_wr && bus_addr == CA) begin
                if (bus_wdata[7] && bus_wdata[6] && m_busy == 0) begin
                    nb = bus_wdata[3] ? WL : WS;
                    m_req = 1;
                    exp_pulses++;
                    exp_w = nb;
                end
                m_ctrl = bus_wdata;
            end
            if (bus_wr && bus_addr == PA) m_port = bus_wdata;
            m_busy = nb;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int er;
            er = 0;
            if (bus_rd) er = (bus_addr == CA) ? m_ctrl : (bus_addr == PA) ? m_port : 0;
            chk("R3/R5 cpu_reset", cpu_reset, m_busy > 0);
            chk("R2/R4 fast_reset_req", fast_reset_req, m_req);
            chk("R7 a20_gate", a20_gate, ((m_port >> 1) & 1) | kbc_a20);
            chk("R8 port_unsup", port_unsup, (m_port & 8'hFD) != 0);
            chk("R6 rdata", bus_rdata, er);
            if (fast_reset_req) seen_pulses++;
            if (cpu_reset) cur_w++;
            else if (cur_w != 0) begin
                chk("R3 measured width", cur_w, exp_w);
                cur_w = 0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            bus_wr = 0; bus_rd = 0;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 0; bus_rd = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 bus_rd = 1; bus_addr = CA;
        @(negedge clk);
        chk("R1 ctrl reset", bus_rdata, 0);
        chk("R1 cpu_reset reset", cpu_reset, 0);
        chk("R1 strobe reset", fast_reset_req, 0);
        chk("R1 a20 reset", a20_gate, 0);
        chk("R1 unsup reset", port_unsup, 0);
        bus_addr = PA;
        #0.1;
        chk("R1 port reset", bus_rdata, 0);
        @(posedge clk); #1 rst_n = 1; bus_rd = 0;
        idle(2);
        // R2/R3 short pulse
        wr(CA, 8'hC0); idle(8);
        // R3 long pulse with R5 retriggers inside and on its last cycle
        wr(CA, 8'hC8); idle(3); wr(CA, 8'hC0); rd(CA); idle(6); wr(CA, 8'hC8);
        // first cycle after the pulse ends: accepted again
        wr(CA, 8'hC0); idle(6);
        // R4 non-qualifying values
        wr(CA, 8'h80); idle(1); wr(CA, 8'h40); rd(CA); wr(CA, 8'h3F); rd(CA); idle(4);
        // R7/R8 port
        wr(PA, 8'h02); rd(PA); kbc_a20 = 1; idle(1); wr(PA, 8'h00); rd(PA);
        kbc_a20 = 0; idle(1); wr(PA, 8'h01); rd(PA); wr(PA, 8'hFF); rd(PA);
        wr(PA, 8'h02); rd(PA); rd(16'h0050); idle(1); rd(CA);
        // long pulse alone, then short
        wr(CA, 8'hCF); idle(14); wr(CA, 8'hC4); idle(6);
        idle(2);
        chk("R2 strobe count", seen_pulses, exp_pulses);
        chk("R2 pulses expected", exp_pulses, 5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule